// File: doc/BRIEF.md
# Two-Bank DDR SRAM Read Sequencer

This block sits between a request source and two double-data-rate synchronous SRAM banks. Both banks share the address, advance/load, write-enable and data lines. The banks are told apart by the second chip enable. One bank takes that enable in its inverted form and the other in its true form. A single bank-select output therefore activates exactly one of them. Each request carries a read/write flag, a bank bit, an address and a two-half write word. Requests arrive through a valid/ready handshake and are turned into one command per cycle on the shared pins.

A bank deselected through its second enable stops its echo clock. A bank that has just been selected therefore needs a moment before it can return read data. When a read targets a different bank than the last command, the sequencer first spends one cycle with the bank select already pointing at the new bank and the first chip enable deasserted. This gives the new bank time to start its echo clock. A write to the new bank warms it up just as well, so writes never pause. For every read it issues, the block also produces a bank tag a fixed number of cycles later, so that downstream capture logic knows which bank is returning data.

Top module: `dbank_rd_seq`

## Requirements
- R1: Reset returns the pins to idle: first enable `mem_e1_n`=1, `mem_adv_n`=1, `mem_we_n`=1, `mem_bank_sel`=0. Reset also clears `rd_tag_valid`, and the remembered last bank becomes bank 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a rising edge. After that edge the pins show the command: `mem_e1_n`=0, `mem_adv_n`=0, `mem_addr` equal to the request address, `mem_bank_sel` equal to the request bank, and `mem_we_n` equal to the inverse of `req_write`.
- R3: A read whose bank differs from the last bank takes one warm-up cycle first. In that cycle `req_ready` is 0 and nothing is consumed. After the edge, the pins show `mem_e1_n`=1, `mem_adv_n`=1 and `mem_bank_sel` set to the new bank. The held request is accepted in the following cycle.
- R4: A write to a bank other than the last one is accepted at once, with no warm-up cycle.
- R5: A read that follows a write to the same bank needs no warm-up cycle, even when that write itself changed the bank.
- R6: Reads to the same bank are accepted on consecutive cycles with no gap.
- R7: With no request, the pins go idle (`mem_e1_n`=1, `mem_adv_n`=1, `mem_we_n`=1) and `mem_bank_sel` keeps its previous value.
- R8: `rd_tag_valid` rises exactly RD_LAT cycles after a read command appears on the pins, with `rd_tag_bank` equal to that read's bank. Writes produce no tag.
- R9: On an accepted write, `mem_wdata` carries the request's write word in the same cycle as the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Target bank (0 or 1) |
| req_addr | input | AW | Word-pair address |
| req_wdata | input | 2*DW | Write word, rising half in upper bits |
| mem_addr | output | AW | Shared address pins |
| mem_adv_n | output | 1 | Advance/load, low loads a new address |
| mem_e1_n | output | 1 | First chip enable to both banks, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bank_sel | output | 1 | Second enable: true on bank 1, inverted on bank 0 |
| mem_wdata | output | 2*DW | Write word for the DDR output stage |
| rd_tag_valid | output | 1 | Read data due from a bank this cycle |
| rd_tag_bank | output | 1 | Bank owning the returning read |

## Verification
The hard situation is a bank change that arrives while the source keeps its request valid through the stalled cycle. The pins must show the new bank with the first enable high, and only then the real read, with the tag pipeline still carrying reads from the old bank. The vector table walks several such switches, each placed right after an idle cycle, a write or a burst of reads. It also covers a write-driven switch followed by a read. A mid-stream reset after a switch to bank 1 shows that the remembered bank returns to 0 and that tags still in flight are dropped.

// File: rtl/dbank_pkg.sv
package dbank_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_PAUSE = 2'd1,
        SLOT_READ  = 2'd2,
        SLOT_WRITE = 2'd3
    } slot_e;

    typedef struct packed {
        logic vld;
        logic bank;
    } tag_t;

    function automatic logic needs_warmup(input logic valid, input logic write,
                                          input logic bank, input logic last_bank);
        return valid && !write && (bank != last_bank);
    endfunction

endpackage

// File: rtl/dbank_arb.sv
module dbank_arb
    import dbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  logic  req_write,
    input  logic  req_bank,
    output logic  req_ready,
    output slot_e slot,
    output logic  slot_bank
);

    logic last_bank;
    logic pause;

    always_comb begin
        pause     = needs_warmup(req_valid, req_write, req_bank, last_bank);
        req_ready = !pause;
        slot_bank = req_valid ? req_bank : last_bank;
        if (!req_valid)     slot = SLOT_IDLE;
        else if (pause)     slot = SLOT_PAUSE;
        else if (req_write) slot = SLOT_WRITE;
        else                slot = SLOT_READ;
    end

    // Both a warm-up and an issued command move the bank select to the new bank.
    always_ff @(posedge clk) begin
        if (rst)            last_bank <= 1'b0;
        else if (req_valid) last_bank <= req_bank;
    end

endmodule

// File: rtl/dbank_issue.sv
module dbank_issue
    import dbank_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  slot_e         slot,
    input  logic          slot_bank,
    input  logic [AW-1:0] addr,
    input  logic [2*DW-1:0] wdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_adv_n,
    output logic          mem_e1_n,
    output logic          mem_we_n,
    output logic          mem_bank_sel,
    output logic [2*DW-1:0] mem_wdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr     <= '0;
            mem_adv_n    <= 1'b1;
            mem_e1_n     <= 1'b1;
            mem_we_n     <= 1'b1;
            mem_bank_sel <= 1'b0;
            mem_wdata    <= '0;
        end else begin
            case (slot)
                SLOT_IDLE: begin
                    mem_adv_n <= 1'b1;
                    mem_e1_n  <= 1'b1;
                    mem_we_n  <= 1'b1;
                end
                SLOT_PAUSE: begin
                    mem_adv_n    <= 1'b1;
                    mem_e1_n     <= 1'b1;
                    mem_we_n     <= 1'b1;
                    mem_bank_sel <= slot_bank;
                end
                SLOT_READ: begin
                    mem_adv_n    <= 1'b0;
                    mem_e1_n     <= 1'b0;
                    mem_we_n     <= 1'b1;
                    mem_bank_sel <= slot_bank;
                    mem_addr     <= addr;
                end
                default: begin
                    mem_adv_n    <= 1'b0;
                    mem_e1_n     <= 1'b0;
                    mem_we_n     <= 1'b0;
                    mem_bank_sel <= slot_bank;
                    mem_addr     <= addr;
                    mem_wdata    <= wdata;
                end
            endcase
        end
    end

    // R7: an idle slot leaves the bank select where it was
    p_sel_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_IDLE) |=> $stable(mem_bank_sel));

endmodule

// File: rtl/dbank_tagpipe.sv
module dbank_tagpipe
    import dbank_pkg::*;
#(
    parameter int RD_LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic push_bank,
    output logic tag_valid,
    output logic tag_bank
);

    tag_t stg [RD_LAT+1];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= '{vld: push, bank: push_bank};
    end

    for (genvar g = 1; g <= RD_LAT; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= '0;
            else     stg[g] <= stg[g-1];
        end
    end

    assign tag_valid = stg[RD_LAT].vld;
    assign tag_bank  = stg[RD_LAT].bank;

endmodule

// File: rtl/dbank_rd_seq.sv
module dbank_rd_seq
    import dbank_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 8,
    parameter int RD_LAT = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic            req_bank,
    input  logic [AW-1:0]   req_addr,
    input  logic [2*DW-1:0] req_wdata,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_adv_n,
    output logic            mem_e1_n,
    output logic            mem_we_n,
    output logic            mem_bank_sel,
    output logic [2*DW-1:0] mem_wdata,
    output logic            rd_tag_valid,
    output logic            rd_tag_bank
);

    slot_e slot;
    logic  slot_bank;

    dbank_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_bank  (req_bank),
        .req_ready (req_ready),
        .slot      (slot),
        .slot_bank (slot_bank)
    );

    dbank_issue #(.AW(AW), .DW(DW)) u_issue (
        .clk          (clk),
        .rst          (rst),
        .slot         (slot),
        .slot_bank    (slot_bank),
        .addr         (req_addr),
        .wdata        (req_wdata),
        .mem_addr     (mem_addr),
        .mem_adv_n    (mem_adv_n),
        .mem_e1_n     (mem_e1_n),
        .mem_we_n     (mem_we_n),
        .mem_bank_sel (mem_bank_sel),
        .mem_wdata    (mem_wdata)
    );

    dbank_tagpipe #(.RD_LAT(RD_LAT)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .push      (slot == SLOT_READ),
        .push_bank (slot_bank),
        .tag_valid (rd_tag_valid),
        .tag_bank  (rd_tag_bank)
    );

    // Pin-level history used by the checks below.
    logic last_cmd_bank_q, prev_e1n_q, prev_sel_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            last_cmd_bank_q <= 1'b0;
            prev_e1n_q      <= 1'b1;
            prev_sel_q      <= 1'b0;
        end else begin
            if (!mem_e1_n) last_cmd_bank_q <= mem_bank_sel;
            prev_e1n_q <= mem_e1_n;
            prev_sel_q <= mem_bank_sel;
        end
    end

    // R2: an accepted request loads a command onto the pins
    p_accept_loads_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!mem_adv_n && !mem_e1_n));

    // R3: a stalled request yields a deselected cycle pointed at its bank
    p_stall_warms_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (mem_e1_n && mem_bank_sel == $past(req_bank)));

    // R3: a read on a new bank is preceded by a deselected cycle on that bank
    p_switch_preceded_r3: assert property (@(posedge clk) disable iff (rst)
        (!mem_e1_n && mem_we_n && mem_bank_sel != last_cmd_bank_q)
        |-> (prev_e1n_q && prev_sel_q == mem_bank_sel));

endmodule

// File: tb/test_dbank_rd_seq.sv
module test_dbank_rd_seq;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int RD_LAT = 3;
    localparam int NV = 16;

    // {valid, write, bank, addr[7:0], exp_ready, exp_e1n, exp_advn, exp_sel}
    localparam logic [14:0] VEC [NV] = '{
        15'b1_0_0_00000001_1_0_0_0,   // read b0 (R2)
        15'b1_0_0_00000010_1_0_0_0,   // read b0 back-to-back (R6)
        15'b1_0_1_00000011_0_1_1_1,   // read b1: warm-up (R3)
        15'b1_0_1_00000011_1_0_0_1,   // held read issued (R3)
        15'b1_0_1_00000100_1_0_0_1,   // read b1 (R6)
        15'b1_1_0_00000101_1_0_0_0,   // write b0, no pause (R4)
        15'b1_0_0_00000110_1_0_0_0,   // read b0 after write (R5)
        15'b0_0_0_00000000_1_1_1_0,   // idle (R7)
        15'b1_0_1_00000111_0_1_1_1,   // warm-up after idle (R3)
        15'b1_0_1_00000111_1_0_0_1,
        15'b1_1_0_00001000_1_0_0_0,   // write b0 (R4)
        15'b1_0_1_00001001_0_1_1_1,   // warm-up after write (R3)
        15'b1_0_1_00001001_1_0_0_1,
        15'b1_1_0_00001010_1_0_0_0,   // write switch (R4)
        15'b0_0_0_00000000_1_1_1_0,   // idle (R7)
        15'b0_0_0_00000000_1_1_1_0
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [2*DW-1:0] req_wdata = '0;
    logic req_ready;
    logic [AW-1:0] mem_addr;
    logic mem_adv_n, mem_e1_n, mem_we_n, mem_bank_sel;
    logic [2*DW-1:0] mem_wdata;
    logic rd_tag_valid, rd_tag_bank;

    int n_run = 0;
    int n_fail = 0;
    bit exp_tv [NV+RD_LAT];
    bit exp_tb [NV+RD_LAT];

    always #2.5 clk = ~clk;

    dbank_rd_seq #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT)) i_dbank_rd_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_addr(mem_addr), .mem_adv_n(mem_adv_n), .mem_e1_n(mem_e1_n),
        .mem_we_n(mem_we_n), .mem_bank_sel(mem_bank_sel), .mem_wdata(mem_wdata),
        .rd_tag_valid(rd_tag_valid), .rd_tag_bank(rd_tag_bank)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2*DW-1:0] wword(input logic [AW-1:0] a);
        return {a, a ^ 8'hA5};
    endfunction

    task automatic drive(input logic v, input logic w, input logic b,
                         input logic [AW-1:0] a);
        req_valid = v; req_write = w; req_bank = b;
        req_addr = a;  req_wdata = wword(a);
    endtask

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NV + RD_LAT; i++) begin
            exp_tv[i] = 1'b0; exp_tb[i] = 1'b0;
        end
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][14] && !VEC[i][13] && VEC[i][3]) begin
                exp_tv[i+RD_LAT] = 1'b1;
                exp_tb[i+RD_LAT] = VEC[i][12];
            end
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state on the pins
        chk("R1", "e1_n", {31'd0, mem_e1_n}, 32'd1);
        chk("R1", "adv_n", {31'd0, mem_adv_n}, 32'd1);
        chk("R1", "we_n", {31'd0, mem_we_n}, 32'd1);
        chk("R1", "bank_sel", {31'd0, mem_bank_sel}, 32'd0);
        chk("R1", "tag_valid", {31'd0, rd_tag_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:4]);
            #1;
            chk(VEC[i][3] ? "R2" : "R3", "ready", {31'd0, req_ready}, {31'd0, VEC[i][3]});
            @(posedge clk);
            @(negedge clk);
            chk(VEC[i][2] ? "R7" : "R2", "e1_n", {31'd0, mem_e1_n}, {31'd0, VEC[i][2]});
            chk("R2", "adv_n", {31'd0, mem_adv_n}, {31'd0, VEC[i][1]});
            chk("R7", "bank_sel", {31'd0, mem_bank_sel}, {31'd0, VEC[i][0]});
            chk("R2", "we_n", {31'd0, mem_we_n},
                {31'd0, !(VEC[i][14] && VEC[i][13] && VEC[i][3])});
            if (VEC[i][14] && VEC[i][3])
                chk("R2", "addr", {24'd0, mem_addr}, {24'd0, VEC[i][11:4]});
            if (VEC[i][14] && VEC[i][13])
                chk("R9", "wdata", {16'd0, mem_wdata}, {16'd0, wword(VEC[i][11:4])});
            chk("R8", "tag_valid", {31'd0, rd_tag_valid}, {31'd0, exp_tv[i]});
            if (exp_tv[i])
                chk("R8", "tag_bank", {31'd0, rd_tag_bank}, {31'd0, exp_tb[i]});
        end

        // R1: switch to bank 1, reset with a tag in flight, then bank 0 reads need no pause
        drive(1'b1, 1'b0, 1'b1, 8'h40);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk("R3", "bank_sel", {31'd0, mem_bank_sel}, 32'd1);
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R1", "bank_sel after reset", {31'd0, mem_bank_sel}, 32'd0);
        repeat (RD_LAT) begin
            @(posedge clk); @(negedge clk);
            chk("R1", "tag dropped", {31'd0, rd_tag_valid}, 32'd0);
        end
        drive(1'b1, 1'b0, 1'b0, 8'h41);
        #1;
        chk("R1", "ready on bank 0", {31'd0, req_ready}, 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R1", "issue bank 0", {31'd0, mem_e1_n}, 32'd0);
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        repeat (RD_LAT - 1) @(posedge clk);
        @(negedge clk);
        chk("R8", "late tag", {31'd0, rd_tag_valid}, 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R8", "tag on time", {31'd0, rd_tag_valid}, 32'd1);
        chk("R8", "tag bank", {31'd0, rd_tag_bank}, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule